// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block lets a host and an embedded engine exchange messages through two independent circular buffers of 32-bit slots, one for each direction. Each side has an identical four-word register port. It holds a window that pushes a slot into the buffer this side sends on, and a window that pops a slot from the buffer this side receives on. It also holds the side's own control/status word and a read-only view of the other side's control/status word.

The control/status word holds both pointers and the depth of the buffer its side sends on. Software on either side can therefore compute the free space for sending, and the other side can compute how many slots are waiting for it. The pointers are free-running 8-bit counters. Occupancy is their modulo-256 difference. The buffer index is the low bits of a pointer, so the depth must be a power of two from 2 to 128.

The same word carries the doorbell bits: an interrupt enable, a sticky interrupt status, and a generate bit that rings the other side. It also carries ready and reset flags used in a two-step reset handshake, and a sticky overflow flag. Reads on either port return data on the cycle after the read strobe.

Top module: `mbx_doorbell`

## Requirements
- R1: Word index 0 is the send window, 1 the own control/status word, 2 the receive window and 3 the peer control/status word. Read data appears the cycle after the read strobe. Reading index 0 returns zero, and writes to index 2 or index 3 change no state on either side.
- R2: Own control/status layout: bit0 interrupt enable, bit1 interrupt status, bit2 generate (reads 0), bit3 ready, bit4 reset, bit5 overflow, bits[15:8] read pointer, bits[23:16] write pointer, bits[31:24] depth in slots, bits 7:6 zero. After reset every bit is zero except the depth field.
- R3: A write to the send window stores the word and advances the write pointer by one. The occupancy is (write pointer − read pointer) mod 256.
- R4: A read of the receive window returns the oldest stored word of the peer's send buffer and advances that buffer's read pointer by one.
- R5: A send-window write while occupancy equals the depth is dropped and sets the sticky overflow bit. Writing 1 to bit5 clears it.
- R6: A receive-window read of an empty buffer returns zero and leaves both pointers unchanged.
- R7: Writing 1 to bit1 clears interrupt status. A doorbell from the peer sets it, and a set wins over a clear in the same cycle.
- R8: Writing 1 to bit2 sets the peer's interrupt status. Bit2 always reads 0.
- R9: Each side's interrupt output is high exactly when its enable and status bits are both 1.
- R10: While a side's reset bit is 1, the pointers of the buffer it sends on are held at zero, its ready bit reads 0, and its send-window writes are ignored without setting overflow.
- R11: Writing reset 0 with ready 1 and generate 1 completes the handshake: ready reads 1, the buffer starts empty, and the peer's status is set.
- R12: Occupancy and data order stay correct after the 8-bit pointers wrap past 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host word index |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after h_rd |
| h_irq | output | 1 | Host interrupt |
| e_wr | input | 1 | Engine write strobe |
| e_rd | input | 1 | Engine read strobe |
| e_addr | input | 2 | Engine word index |
| e_wdata | input | 32 | Engine write data |
| e_rdata | output | 32 | Engine read data, valid the cycle after e_rd |
| e_irq | output | 1 | Engine interrupt |

## Verification
The assertions check these properties on every cycle:
- occupancy never exceeds the depth;
- a dropped push leaves the write pointer and sets overflow;
- an empty pop leaves the read pointer alone;
- a held reset bit zeroes the pointers;
- a doorbell always lands in the peer status.

Data order, the exact control/status encoding, write-one-to-clear behaviour, the set-over-clear race, the handshake sequence and wrap-around of the pointers are shown only by the bench scenarios. The bench sweeps every fill level of a depth-4 configuration in both directions and runs enough transfers to carry the pointers past 255.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W  = 32;
  localparam int PTR_W   = 8;
  localparam int B_IE    = 0;
  localparam int B_IS    = 1;
  localparam int B_IG    = 2;
  localparam int B_RDY   = 3;
  localparam int B_RST   = 4;
  localparam int B_OVF   = 5;

  typedef enum logic [1:0] {
    SEL_SEND  = 2'd0,
    SEL_OWN   = 2'd1,
    SEL_RECV  = 2'd2,
    SEL_PEER  = 2'd3
  } mbx_sel_e;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [mbx_pkg::WORD_W-1:0] push_data,
  input  logic                       pop,
  output logic                       pop_ok,
  output logic                       push_drop,
  output logic [mbx_pkg::PTR_W-1:0]  wptr,
  output logic [mbx_pkg::PTR_W-1:0]  rptr,
  output logic [mbx_pkg::WORD_W-1:0] pop_data
);
  import mbx_pkg::*;
  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q, filled;
  logic              full, empty, push_ok;

  assign filled    = wp_q - rp_q;
  assign full      = (filled == PTR_W'(DEPTH));
  assign empty     = (filled == '0);
  assign push_ok   = push && !full && !clr;
  assign push_drop = push && full && !clr;
  assign pop_ok    = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q[IDX_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) pop_data <= mem[rp_q[IDX_W-1:0]];
  end

  assign wptr = wp_q;
  assign rptr = rp_q;

  // R3: occupancy bound
  assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (rst)
    filled <= PTR_W'(DEPTH));
  // R5: a dropped push leaves the write pointer where it was
  assert_drop_holds_wptr_R5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !clr) |=> (wp_q == $past(wp_q)));
  // R6: an empty pop leaves the read pointer where it was
  assert_empty_pop_holds_rptr_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !clr) |=> $stable(rp_q));
  // R10: a held reset bit zeroes both pointers
  assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (wp_q == '0 && rp_q == '0));
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [1:0]                 addr,
  input  logic [mbx_pkg::WORD_W-1:0] wdata,
  output logic [mbx_pkg::WORD_W-1:0] rdata,
  output logic                       irq,
  output logic                       push,
  output logic [mbx_pkg::WORD_W-1:0] push_data,
  output logic                       pop,
  input  logic                       pop_ok,
  input  logic [mbx_pkg::WORD_W-1:0] pop_data,
  input  logic [mbx_pkg::PTR_W-1:0]  ring_wptr,
  input  logic [mbx_pkg::PTR_W-1:0]  ring_rptr,
  input  logic                       push_drop,
  output logic                       bell_out,
  input  logic                       bell_in,
  output logic                       clr,
  output logic [mbx_pkg::WORD_W-1:0] csr_out,
  input  logic [mbx_pkg::WORD_W-1:0] peer_csr
);
  import mbx_pkg::*;

  mbx_sel_e          sel;
  logic              csr_wr;
  logic              ie_q, is_q, rdy_q, rb_q, ovf_q;
  logic              use_mem_q;
  logic [WORD_W-1:0] snap_q;

  assign sel       = mbx_sel_e'(addr);
  assign csr_wr    = wr_en && (sel == SEL_OWN);
  assign push      = wr_en && (sel == SEL_SEND);
  assign push_data = wdata;
  assign pop       = rd_en && (sel == SEL_RECV);
  assign bell_out  = csr_wr && wdata[B_IG];
  assign clr       = rb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      is_q  <= 1'b0;
      rdy_q <= 1'b0;
      rb_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (csr_wr) begin
        ie_q  <= wdata[B_IE];
        rdy_q <= wdata[B_RDY];
        rb_q  <= wdata[B_RST];
      end
      is_q  <= bell_in   || (is_q  && !(csr_wr && wdata[B_IS]));
      ovf_q <= push_drop || (ovf_q && !(csr_wr && wdata[B_OVF]));
    end
  end

  assign csr_out = {PTR_W'(DEPTH), ring_wptr, ring_rptr, 2'b00,
                    ovf_q, rb_q, rdy_q && !rb_q, 1'b0, is_q, ie_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      use_mem_q <= 1'b0;
      snap_q    <= '0;
    end else if (rd_en) begin
      use_mem_q <= pop_ok;
      unique case (sel)
        SEL_OWN:  snap_q <= csr_out;
        SEL_PEER: snap_q <= peer_csr;
        default:  snap_q <= '0;
      endcase
    end
  end

  assign rdata = use_mem_q ? pop_data : snap_q;
  assign irq   = ie_q && is_q;

  // R7: a doorbell from the peer always lands in interrupt status
  assert_bell_sets_status_R7: assert property (@(posedge clk) disable iff (rst)
    bell_in |=> is_q);
  // R5: a dropped push raises the sticky overflow flag
  assert_drop_sets_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    push_drop |=> ovf_q);
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [1:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_irq,
  input  logic        e_wr,
  input  logic        e_rd,
  input  logic [1:0]  e_addr,
  input  logic [31:0] e_wdata,
  output logic [31:0] e_rdata,
  output logic        e_irq
);
  import mbx_pkg::*;

  logic              wr_en   [2];
  logic              rd_en   [2];
  logic [1:0]        addr    [2];
  logic [WORD_W-1:0] wdata   [2];
  logic [WORD_W-1:0] rdata   [2];
  logic              irq     [2];
  logic              push    [2];
  logic              pop     [2];
  logic              pop_ok  [2];
  logic              drop    [2];
  logic              bell    [2];
  logic              clr     [2];
  logic [WORD_W-1:0] push_d  [2];
  logic [WORD_W-1:0] pop_d   [2];
  logic [WORD_W-1:0] csr     [2];
  logic [PTR_W-1:0]  wptr    [2];
  logic [PTR_W-1:0]  rptr    [2];

  assign wr_en[0] = h_wr;    assign wr_en[1] = e_wr;
  assign rd_en[0] = h_rd;    assign rd_en[1] = e_rd;
  assign addr[0]  = h_addr;  assign addr[1]  = e_addr;
  assign wdata[0] = h_wdata; assign wdata[1] = e_wdata;
  assign h_rdata  = rdata[0];
  assign e_rdata  = rdata[1];
  assign h_irq    = irq[0];
  assign e_irq    = irq[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int P = 1 - s;

    mbx_ring #(.DEPTH(DEPTH)) u_ring (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr[s]),
      .push      (push[s]),
      .push_data (push_d[s]),
      .pop       (pop[P]),
      .pop_ok    (pop_ok[s]),
      .push_drop (drop[s]),
      .wptr      (wptr[s]),
      .rptr      (rptr[s]),
      .pop_data  (pop_d[s])
    );

    mbx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en[s]),
      .rd_en     (rd_en[s]),
      .addr      (addr[s]),
      .wdata     (wdata[s]),
      .rdata     (rdata[s]),
      .irq       (irq[s]),
      .push      (push[s]),
      .push_data (push_d[s]),
      .pop       (pop[s]),
      .pop_ok    (pop_ok[P]),
      .pop_data  (pop_d[P]),
      .ring_wptr (wptr[s]),
      .ring_rptr (rptr[s]),
      .push_drop (drop[s]),
      .bell_out  (bell[s]),
      .bell_in   (bell[P]),
      .clr       (clr[s]),
      .csr_out   (csr[s]),
      .peer_csr  (csr[P])
    );
  end
endmodule

// File: tb/mbx_doorbell_tb.sv
module mbx_doorbell_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr = 0, h_rd = 0, e_wr = 0, e_rd = 0;
  logic [1:0]  h_addr = 0, e_addr = 0;
  logic [31:0] h_wdata = 0, e_wdata = 0;
  logic [31:0] h_rdata, e_rdata;
  logic        h_irq, e_irq;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mw [2], mr [2];
  int         seqw [2], seqr [2];
  logic       mie [2], mis [2], mrdy [2], mclr [2], movf [2];

  always #4 clk = ~clk;

  mbx_doorbell #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .e_wr(e_wr), .e_rd(e_rd), .e_addr(e_addr), .e_wdata(e_wdata),
    .e_rdata(e_rdata), .e_irq(e_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ecsr(input int s);
    return {8'(DEPTH), mw[s], mr[s], 2'b00, movf[s], mclr[s],
            mrdy[s] & ~mclr[s], 1'b0, mis[s], mie[s]};
  endfunction

  task automatic wr(input int side, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin h_wr = 1; h_addr = a; h_wdata = d; end
    else           begin e_wr = 1; e_addr = a; e_wdata = d; end
    @(negedge clk);
    h_wr = 0; e_wr = 0;
  endtask

  task automatic rd(input int side, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin h_rd = 1; h_addr = a; end
    else           begin e_rd = 1; e_addr = a; end
    @(negedge clk);
    h_rd = 0; e_rd = 0;
    d = (side == 0) ? h_rdata : e_rdata;
  endtask

  task automatic push(input int s);
    logic [31:0] d;
    d = {8'(s + 1), 8'h5A, 16'(seqw[s])};
    wr(s, 2'd0, d);
    if (!mclr[s]) begin
      if (8'(mw[s] - mr[s]) != 8'(DEPTH)) begin
        mw[s] = mw[s] + 8'd1;
        seqw[s]++;
      end else movf[s] = 1'b1;
    end
  endtask

  task automatic pop_chk(input int side, input string req);
    logic [31:0] d;
    int r;
    r = 1 - side;
    rd(side, 2'd2, d);
    if (mw[r] != mr[r]) begin
      chk(req, d, {8'(r + 1), 8'h5A, 16'(seqr[r])});
      mr[r] = mr[r] + 8'd1;
      seqr[r]++;
    end else chk(req, d, 32'h0);
  endtask

  task automatic csr_chk(input int side, input string req);
    logic [31:0] d;
    rd(side, 2'd1, d);
    chk(req, d, ecsr(side));
  endtask

  task automatic csr_wr(input int side, input logic [31:0] v);
    wr(side, 2'd1, v);
    mie[side]  = v[0];
    mrdy[side] = v[3];
    mclr[side] = v[4];
    if (v[1]) mis[side] = 1'b0;
    if (v[5]) movf[side] = 1'b0;
    if (v[2]) mis[1 - side] = 1'b1;
    if (v[4]) begin mw[side] = 0; mr[side] = 0; seqr[side] = seqw[side]; end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int s = 0; s < 2; s++) begin
      mw[s] = 0; mr[s] = 0; seqw[s] = 0; seqr[s] = 0;
      mie[s] = 0; mis[s] = 0; mrdy[s] = 0; mclr[s] = 0; movf[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;

    // R2: reset state of both words, R9 interrupts low
    csr_chk(0, "R2");
    csr_chk(1, "R2");
    chk("R9", {31'b0, h_irq}, 32'h0);
    chk("R9", {31'b0, e_irq}, 32'h0);
    pop_chk(0, "R6");

    // R3/R4: every fill level, host to engine; R1 peer view
    for (int n = 1; n <= DEPTH; n++) begin
      repeat (n) push(0);
      csr_chk(0, "R3");
      rd(1, 2'd3, d);
      chk("R1", d, ecsr(0));
      repeat (n) pop_chk(1, "R4");
      csr_chk(0, "R4");
    end
    // R3/R4: engine to host
    for (int n = 1; n <= DEPTH; n++) begin
      repeat (n) push(1);
      csr_chk(1, "R3");
      rd(0, 2'd3, d);
      chk("R1", d, ecsr(1));
      repeat (n) pop_chk(0, "R4");
    end

    // R5 overflow, R6 empty pop
    repeat (DEPTH + 1) push(0);
    csr_chk(0, "R5");
    repeat (DEPTH) pop_chk(1, "R5");
    pop_chk(1, "R6");
    csr_chk(0, "R6");
    csr_wr(0, 32'h20);
    csr_chk(0, "R5");

    // R1: send window reads zero; writes to recv window / peer word ignored
    rd(0, 2'd0, d);
    chk("R1", d, 32'h0);
    wr(1, 2'd3, 32'hFFFF_FFFF);
    wr(1, 2'd2, 32'hFFFF_FFFF);
    csr_chk(0, "R1");
    csr_chk(1, "R1");

    // R7/R8/R9 doorbell
    csr_wr(0, 32'h1);
    chk("R9", {31'b0, h_irq}, 32'h0);
    csr_wr(1, 32'h4);
    csr_chk(0, "R7");
    chk("R9", {31'b0, h_irq}, 32'h1);
    csr_chk(1, "R8");
    csr_wr(0, 32'h3);
    csr_chk(0, "R7");
    chk("R9", {31'b0, h_irq}, 32'h0);
    csr_wr(0, 32'h0);
    csr_wr(1, 32'h4);
    chk("R9", {31'b0, h_irq}, 32'h0);
    // R7: clear and doorbell in the same cycle, set wins
    @(negedge clk);
    h_wr = 1; h_addr = 2'd1; h_wdata = 32'h2;
    e_wr = 1; e_addr = 2'd1; e_wdata = 32'h4;
    @(negedge clk);
    h_wr = 0; e_wr = 0;
    mie[0] = 0; mis[0] = 1; mie[1] = 0; mrdy[1] = 0; mclr[1] = 0;
    csr_chk(0, "R7");
    csr_wr(1, 32'h2);

    // R10/R11 reset handshake
    push(0); push(0);
    csr_wr(0, 32'h14);
    csr_chk(0, "R10");
    csr_chk(1, "R10");
    push(0);
    csr_chk(0, "R10");
    csr_wr(1, 32'h2);
    csr_wr(0, 32'h0C);
    csr_chk(0, "R11");
    csr_chk(1, "R11");
    pop_chk(1, "R10");
    csr_wr(1, 32'h8);
    csr_chk(1, "R11");

    // R12 pointer wrap with varying occupancy
    for (int i = 0; i < 120; i++) begin
      int k;
      k = (i % DEPTH) + 1;
      repeat (k) push(0);
      csr_chk(0, "R12");
      repeat (k) pop_chk(1, "R12");
    end
    csr_chk(0, "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule